// File: doc/BRIEF.md
# System Control Register File

This block is a bank of control and status registers reached through a 32-bit APB-style slave port. The port decodes a 4 KB window of word offsets. Software uses it for several jobs:

- set and clear secure-debug status bits;
- record and mask reset causes;
- keep a general retention word;
- program the boot vector-table address of each of two cores;
- hold cores in wait and release them;
- request a system reset.

A group of clock, security, power-sense and wake registers exists only in the extended build of the system. A static version input selects that build: the extended registers are present when its top nibble is 2. Those registers only keep what is written into them. A fixed set of identification bytes sits at the top of the window.

Each access takes the two APB phases. Read data and the error flag are driven during the access phase. A write takes effect at the clock edge that closes the access phase. The outputs are two per-core vector-table values, a per-core release pulse and a system reset request pulse.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset the registers hold the following values. Reset cause (0x100) is 1. System power sense (0x200) is 0x7F. The core-0 and core-1 vector registers (0x110, 0x114) hold the parameters VTOR0_RST and VTOR1_RST. Core hold (0x118) holds HOLD_RST. Every other register is 0.
- R2: Every read/write register returns the last word written to it. The read/write registers are 0x00C, 0x010, 0x014, 0x018, 0x100, 0x104, 0x10C, 0x110, 0x114, 0x118, 0x11C, 0x120, 0x124, 0x200, 0x20C, 0x210, 0x214 and 0x218.
- R3: Debug status at 0x000 is read-only. A write to 0x004 ORs the written word into it. A write to 0x008 clears each bit that is written as 1.
- R4: A read of 0x004, 0x008 or 0x108 returns 0 and raises pslverr.
- R5: A write to 0x108 with bit 9 set drives sys_reset_req high for exactly the one cycle after the write edge. The other bits of that word have no effect.
- R6: A write to 0x118 that changes bit n from 1 to 0 (n = 0 or 1) pulses core_release[n] for exactly one cycle after the write edge. The new word is then stored.
- R7: core_vtor0 and core_vtor1 always show the contents of 0x110 and 0x114. They change only on a write to those offsets.
- R8: The extended registers are present only when sys_version[31:28] equals 2. The extended registers are 0x00C to 0x018, 0x114, 0x124 and 0x200 to 0x218. In the other build they read 0, ignore writes and raise pslverr.
- R9: In the non-extended build, 0x11C reads 0 without an error. A write to it is ignored and raises pslverr.
- R10: Word offsets 0xFD0 to 0xFFC read bytes 04,00,00,00,54,B8,0B,00,0D,F0,05,B1 in ascending address order, zero-extended. Writes to them are ignored and raise pslverr.
- R11: Unmapped offsets read 0, ignore writes and raise pslverr. A write to 0x000 is also ignored with pslverr.
- R12: Address bits [1:0] are ignored. Any byte address selects its whole 32-bit word, and a read returns the whole word.
- R13: Outside the access phase (psel and penable both high), prdata is 0 and pslverr is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_version | input | 32 | Static build version; top nibble selects the extended register set |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pslverr | output | 1 | Access error, valid in the access phase |
| core_vtor0 | output | 32 | Boot vector-table address for core 0 |
| core_vtor1 | output | 32 | Boot vector-table address for core 1 |
| core_release | output | 2 | One-cycle power-up/reset pulse per core |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
prdata and pslverr are combinational from the bus, so the bench samples them one time unit after the falling edge that starts the access phase. The same check also confirms that both outputs are zero during the setup phase. A written value becomes visible at the rising edge that closes the access phase. The bench therefore compares the vector outputs at the following falling edge, and compares register contents through a later read. The release and reset-request pulses are registered. They are due in the single cycle after the write edge, so the bench samples them at the next falling edge and again one cycle later, when they must be zero. Two instances, one in each build, share the bus. A model in the bench, keyed by word offset, predicts the data, the error flag and the pulses of every access in sweeps over all 1024 word offsets.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int WORD_W      = 32;
    localparam int OFFS_W      = 12;
    localparam int WIDX_W      = OFFS_W - 2;
    localparam int NUM_CORES   = 2;
    localparam int SWRST_BIT   = 9;
    localparam int IDENT_WORDS = 12;
    localparam int IDENT_IDX_W = $clog2(IDENT_WORDS);
    localparam logic [WIDX_W-1:0] IDENT_BASE = WIDX_W'(1024 - IDENT_WORDS);

    typedef enum logic [4:0] {
        RID_NONE,
        RID_DBG_STAT,
        RID_DBG_SET,
        RID_DBG_CLR,
        RID_SEC_CTL,
        RID_FCLK_DIV,
        RID_SCLK_DIV,
        RID_CLK_FORCE,
        RID_RST_CAUSE,
        RID_RST_MASK,
        RID_SW_RST,
        RID_RETAIN,
        RID_VTOR0,
        RID_VTOR1,
        RID_CORE_HOLD,
        RID_NMI_EN,
        RID_WAKE_IRQ,
        RID_EXT_WAKE,
        RID_PD_SYS,
        RID_PD_MEM0,
        RID_PD_MEM1,
        RID_PD_MEM2,
        RID_PD_MEM3,
        RID_IDENT
    } reg_id_e;

    localparam int NUM_RID = 24;

    typedef struct packed {
        reg_id_e id;
        logic    ext_only;
        logic    rd_ok;
        logic    wr_ok;
    } reg_info_t;

    typedef struct packed {
        reg_id_e                id;
        logic                   rd;
        logic                   wr;
        logic                   err;
        logic [IDENT_IDX_W-1:0] ident_idx;
    } access_t;

    function automatic reg_info_t mk_info(reg_id_e id, logic ext, logic rd, logic wr);
        reg_info_t r;
        r.id       = id;
        r.ext_only = ext;
        r.rd_ok    = rd;
        r.wr_ok    = wr;
        return r;
    endfunction

    // Word-offset map; offsets are the byte offset divided by four.
    function automatic reg_info_t lookup_word(logic [WIDX_W-1:0] w);
        reg_info_t r;
        r = mk_info(RID_NONE, 1'b0, 1'b0, 1'b0);
        case (w)
            10'h000: r = mk_info(RID_DBG_STAT,  1'b0, 1'b1, 1'b0);
            10'h001: r = mk_info(RID_DBG_SET,   1'b0, 1'b0, 1'b1);
            10'h002: r = mk_info(RID_DBG_CLR,   1'b0, 1'b0, 1'b1);
            10'h003: r = mk_info(RID_SEC_CTL,   1'b1, 1'b1, 1'b1);
            10'h004: r = mk_info(RID_FCLK_DIV,  1'b1, 1'b1, 1'b1);
            10'h005: r = mk_info(RID_SCLK_DIV,  1'b1, 1'b1, 1'b1);
            10'h006: r = mk_info(RID_CLK_FORCE, 1'b1, 1'b1, 1'b1);
            10'h040: r = mk_info(RID_RST_CAUSE, 1'b0, 1'b1, 1'b1);
            10'h041: r = mk_info(RID_RST_MASK,  1'b0, 1'b1, 1'b1);
            10'h042: r = mk_info(RID_SW_RST,    1'b0, 1'b0, 1'b1);
            10'h043: r = mk_info(RID_RETAIN,    1'b0, 1'b1, 1'b1);
            10'h044: r = mk_info(RID_VTOR0,     1'b0, 1'b1, 1'b1);
            10'h045: r = mk_info(RID_VTOR1,     1'b1, 1'b1, 1'b1);
            10'h046: r = mk_info(RID_CORE_HOLD, 1'b0, 1'b1, 1'b1);
            10'h047: r = mk_info(RID_NMI_EN,    1'b0, 1'b1, 1'b1);
            10'h048: r = mk_info(RID_WAKE_IRQ,  1'b0, 1'b1, 1'b1);
            10'h049: r = mk_info(RID_EXT_WAKE,  1'b1, 1'b1, 1'b1);
            10'h080: r = mk_info(RID_PD_SYS,    1'b1, 1'b1, 1'b1);
            10'h083: r = mk_info(RID_PD_MEM0,   1'b1, 1'b1, 1'b1);
            10'h084: r = mk_info(RID_PD_MEM1,   1'b1, 1'b1, 1'b1);
            10'h085: r = mk_info(RID_PD_MEM2,   1'b1, 1'b1, 1'b1);
            10'h086: r = mk_info(RID_PD_MEM3,   1'b1, 1'b1, 1'b1);
            default: begin
                if (w >= IDENT_BASE) r = mk_info(RID_IDENT, 1'b0, 1'b1, 1'b0);
            end
        endcase
        return r;
    endfunction

    // Registers that simply keep the written word.
    function automatic logic is_plain(reg_id_e id);
        case (id)
            RID_SEC_CTL, RID_FCLK_DIV, RID_SCLK_DIV, RID_CLK_FORCE,
            RID_RST_CAUSE, RID_RST_MASK, RID_RETAIN, RID_NMI_EN,
            RID_WAKE_IRQ, RID_EXT_WAKE, RID_PD_SYS,
            RID_PD_MEM0, RID_PD_MEM1, RID_PD_MEM2, RID_PD_MEM3: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] plain_reset(reg_id_e id);
        case (id)
            RID_RST_CAUSE: return WORD_W'(32'h1);
            RID_PD_SYS:    return WORD_W'(32'h7F);
            default:       return '0;
        endcase
    endfunction

    function automatic logic [7:0] ident_byte(logic [IDENT_IDX_W-1:0] idx);
        case (idx)
            4'd0:    return 8'h04;
            4'd4:    return 8'h54;
            4'd5:    return 8'hB8;
            4'd6:    return 8'h0B;
            4'd8:    return 8'h0D;
            4'd9:    return 8'hF0;
            4'd10:   return 8'h05;
            4'd11:   return 8'hB1;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter logic [3:0] EXT_TAG = 4'd2
) (
    input  logic [3:0]        version_tag,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [WIDX_W-1:0] word_idx,
    output access_t           acc
);

    reg_info_t         info;
    logic              ext_en;
    logic              present;
    logic              wr_allow;
    logic              active;
    logic [WIDX_W-1:0] ident_rel;

    always_comb begin
        info      = lookup_word(word_idx);
        ext_en    = (version_tag == EXT_TAG);
        present   = (info.id != RID_NONE) && (!info.ext_only || ext_en);
        // The NMI location is read-only zero outside the extended build.
        wr_allow  = info.wr_ok && !((info.id == RID_NMI_EN) && !ext_en);
        active    = psel && penable;
        ident_rel = word_idx - IDENT_BASE;

        acc.id        = present ? info.id : RID_NONE;
        acc.rd        = active && !pwrite && present && info.rd_ok;
        acc.wr        = active &&  pwrite && present && wr_allow;
        acc.err       = active && !(acc.rd || acc.wr);
        acc.ident_idx = ident_rel[IDENT_IDX_W-1:0];
    end

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_id_e           wr_id,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] vals [NUM_RID]
);

    for (genvar i = 0; i < NUM_RID; i++) begin : g_slot
        if (is_plain(reg_id_e'(i))) begin : g_reg
            logic [WORD_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= plain_reset(reg_id_e'(i));
                else if (wr_en && (wr_id == reg_id_e'(i)))
                    q <= wdata;
            end
            assign vals[i] = q;
        end else begin : g_none
            assign vals[i] = '0;
        end
    end

endmodule

// File: rtl/sysctl_dbg.sv
module sysctl_dbg
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] status
);

    always_ff @(posedge clk) begin
        if (rst)
            status <= '0;
        else if (set_en)
            status <= status | wdata;
        else if (clr_en)
            status <= status & ~wdata;
    end

endmodule

// File: rtl/sysctl_cores.sv
module sysctl_cores
    import sysctl_pkg::*;
#(
    parameter logic [WORD_W-1:0] VTOR0_RST = 32'h1000_0000,
    parameter logic [WORD_W-1:0] VTOR1_RST = 32'h1000_0000,
    parameter logic [WORD_W-1:0] HOLD_RST  = 32'h0
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_CORES-1:0]             vtor_wr,
    input  logic                             hold_wr,
    input  logic [WORD_W-1:0]                wdata,
    output logic [NUM_CORES-1:0][WORD_W-1:0] vtor,
    output logic [WORD_W-1:0]                hold,
    output logic [NUM_CORES-1:0]             release_pulse
);

    always_ff @(posedge clk) begin
        if (rst)
            hold <= HOLD_RST;
        else if (hold_wr)
            hold <= wdata;
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        localparam logic [WORD_W-1:0] RV = (c == 0) ? VTOR0_RST : VTOR1_RST;
        logic [WORD_W-1:0] vtor_q;
        logic              rel_q;

        always_ff @(posedge clk) begin
            if (rst)
                vtor_q <= RV;
            else if (vtor_wr[c])
                vtor_q <= wdata;
        end

        // Falling edge of a hold bit releases that core for one cycle.
        always_ff @(posedge clk) begin
            if (rst)
                rel_q <= 1'b0;
            else
                rel_q <= hold_wr && hold[c] && !wdata[c];
        end

        assign vtor[c]          = vtor_q;
        assign release_pulse[c] = rel_q;
    end

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter logic [3:0]  EXT_TAG   = 4'd2,
    parameter logic [31:0] VTOR0_RST = 32'h1000_0000,
    parameter logic [31:0] VTOR1_RST = 32'h1000_0000,
    parameter logic [31:0] HOLD_RST  = 32'h0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] sys_version,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [11:0] paddr,
    input  logic [31:0] pwdata,
    output logic [31:0] prdata,
    output logic        pslverr,
    output logic [31:0] core_vtor0,
    output logic [31:0] core_vtor1,
    output logic [1:0]  core_release,
    output logic        sys_reset_req
);

    access_t                             acc;
    logic [WORD_W-1:0]                   plain_vals [NUM_RID];
    logic [WORD_W-1:0]                   dbg_status;
    logic [NUM_CORES-1:0][WORD_W-1:0]    vtor;
    logic [WORD_W-1:0]                   hold;
    logic [NUM_CORES-1:0]                vtor_wr;
    logic [WORD_W-1:0]                   rd_word;
    logic                                swrst_q;
    logic                                addr_lsb_unused;
    logic                                version_low_unused;

    assign addr_lsb_unused    = ^paddr[1:0];
    assign version_low_unused = ^sys_version[27:0];

    sysctl_decode #(.EXT_TAG(EXT_TAG)) u_decode (
        .version_tag (sys_version[31:28]),
        .psel        (psel),
        .penable     (penable),
        .pwrite      (pwrite),
        .word_idx    (paddr[OFFS_W-1:2]),
        .acc         (acc)
    );

    sysctl_store u_store (
        .clk   (clk),
        .rst   (rst),
        .wr_en (acc.wr),
        .wr_id (acc.id),
        .wdata (pwdata),
        .vals  (plain_vals)
    );

    sysctl_dbg u_dbg (
        .clk    (clk),
        .rst    (rst),
        .set_en (acc.wr && (acc.id == RID_DBG_SET)),
        .clr_en (acc.wr && (acc.id == RID_DBG_CLR)),
        .wdata  (pwdata),
        .status (dbg_status)
    );

    assign vtor_wr[0] = acc.wr && (acc.id == RID_VTOR0);
    assign vtor_wr[1] = acc.wr && (acc.id == RID_VTOR1);

    sysctl_cores #(
        .VTOR0_RST (VTOR0_RST),
        .VTOR1_RST (VTOR1_RST),
        .HOLD_RST  (HOLD_RST)
    ) u_cores (
        .clk           (clk),
        .rst           (rst),
        .vtor_wr       (vtor_wr),
        .hold_wr       (acc.wr && (acc.id == RID_CORE_HOLD)),
        .wdata         (pwdata),
        .vtor          (vtor),
        .hold          (hold),
        .release_pulse (core_release)
    );

    always_ff @(posedge clk) begin
        if (rst)
            swrst_q <= 1'b0;
        else
            swrst_q <= acc.wr && (acc.id == RID_SW_RST) && pwdata[SWRST_BIT];
    end

    always_comb begin
        case (acc.id)
            RID_DBG_STAT:  rd_word = dbg_status;
            RID_VTOR0:     rd_word = vtor[0];
            RID_VTOR1:     rd_word = vtor[1];
            RID_CORE_HOLD: rd_word = hold;
            RID_IDENT:     rd_word = {24'h0, ident_byte(acc.ident_idx)};
            default:       rd_word = plain_vals[acc.id];
        endcase
    end

    assign prdata        = acc.rd ? rd_word : '0;
    assign pslverr       = acc.err;
    assign core_vtor0    = vtor[0];
    assign core_vtor1    = vtor[1];
    assign sys_reset_req = swrst_q;

endmodule

// File: rtl/sysctl_checker.sv
module sysctl_checker (
    input logic        clk,
    input logic        rst,
    input logic        psel,
    input logic        penable,
    input logic        pwrite,
    input logic [11:0] paddr,
    input logic [31:0] pwdata,
    input logic [31:0] prdata,
    input logic        pslverr,
    input logic [31:0] core_vtor0,
    input logic [31:0] core_vtor1,
    input logic [1:0]  core_release,
    input logic        sys_reset_req
);

    p_sysrst_single_r5: assert property (@(posedge clk) disable iff (rst)
        sys_reset_req |=> !sys_reset_req);

    p_sysrst_cause_r5: assert property (@(posedge clk) disable iff (rst)
        sys_reset_req |-> $past(psel && penable && pwrite &&
                                paddr[11:2] == 10'h042 && pwdata[9]));

    p_release0_single_r6: assert property (@(posedge clk) disable iff (rst)
        core_release[0] |=> !core_release[0]);

    p_release1_single_r6: assert property (@(posedge clk) disable iff (rst)
        core_release[1] |=> !core_release[1]);

    p_release0_cause_r6: assert property (@(posedge clk) disable iff (rst)
        core_release[0] |-> $past(psel && penable && pwrite &&
                                  paddr[11:2] == 10'h046 && !pwdata[0]));

    p_release1_cause_r6: assert property (@(posedge clk) disable iff (rst)
        core_release[1] |-> $past(psel && penable && pwrite &&
                                  paddr[11:2] == 10'h046 && !pwdata[1]));

    p_vtor_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(psel && penable && pwrite) |=> ($stable(core_vtor0) && $stable(core_vtor1)));

    p_wo_read_err_r4: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && !pwrite && paddr[11:2] == 10'h001) |-> (pslverr && prdata == 32'h0));

    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (rst)
        !(psel && penable) |-> (prdata == 32'h0 && !pslverr));

endmodule

bind sysctl_regfile sysctl_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .psel          (psel),
    .penable       (penable),
    .pwrite        (pwrite),
    .paddr         (paddr),
    .pwdata        (pwdata),
    .prdata        (prdata),
    .pslverr       (pslverr),
    .core_vtor0    (core_vtor0),
    .core_vtor1    (core_vtor1),
    .core_release  (core_release),
    .sys_reset_req (sys_reset_req)
);

// File: tb/sysctl_regfile_test.sv
module sysctl_regfile_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        psel, penable, pwrite;
    logic [11:0] paddr;
    logic [31:0] pwdata;
    logic [31:0] prd   [2];
    logic        perr  [2];
    logic [31:0] vt0   [2];
    logic [31:0] vt1   [2];
    logic [1:0]  rel   [2];
    logic        srr   [2];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Instance 0 = extended build, instance 1 = base build.
    logic [31:0] sh [2][1024];

    always #4 clk = ~clk;

    sysctl_regfile #(.HOLD_RST(32'h3)) uut (
        .clk(clk), .rst(rst), .sys_version(32'h2041_0000),
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prd[0]), .pslverr(perr[0]), .core_vtor0(vt0[0]), .core_vtor1(vt1[0]),
        .core_release(rel[0]), .sys_reset_req(srr[0])
    );

    sysctl_regfile #(.VTOR0_RST(32'h2000_0040), .VTOR1_RST(32'h3000_0080)) uut_base (
        .clk(clk), .rst(rst), .sys_version(32'h1000_0000),
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prd[1]), .pslverr(perr[1]), .core_vtor0(vt0[1]), .core_vtor1(vt1[1]),
        .core_release(rel[1]), .sys_reset_req(srr[1])
    );

    // 0 unmapped/absent, 1 read-write, 2 debug status, 3 set, 4 clear,
    // 5 software reset, 6 identification, 7 read-only zero (base NMI)
    function automatic int cls(int w, bit ext);
        case (w)
            'h000: return 2;
            'h001: return 3;
            'h002: return 4;
            'h042: return 5;
            'h003, 'h004, 'h005, 'h006, 'h045, 'h049,
            'h080, 'h083, 'h084, 'h085, 'h086: return ext ? 1 : 0;
            'h047: return ext ? 1 : 7;
            'h040, 'h041, 'h043, 'h044, 'h046, 'h048: return 1;
            default: return (w >= 'h3F4) ? 6 : 0;
        endcase
    endfunction

    function automatic logic [7:0] id_byte(int i);
        case (i)
            0: return 8'h04;  4: return 8'h54;  5: return 8'hB8;  6: return 8'h0B;
            8: return 8'h0D;  9: return 8'hF0; 10: return 8'h05; 11: return 8'hB1;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(int i, int w);
        int c = cls(w, i == 0);
        if (c == 1 || c == 2) return sh[i][w];
        if (c == 6) return {24'h0, id_byte(w - 'h3F4)};
        return 32'h0;
    endfunction

    function automatic string tag_of(int i, int w, string dflt);
        int c = cls(w, i == 0);
        if (c == 7) return "R9";
        if (c == 6) return "R10";
        if (c == 3 || c == 4 || c == 5) return "R4";
        if (c == 0 && cls(w, 1'b1) != 0) return "R8";
        if (c == 0) return "R11";
        return dflt;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic reset_shadow();
        for (int i = 0; i < 2; i++) begin
            for (int w = 0; w < 1024; w++) sh[i][w] = 32'h0;
            sh[i]['h040] = 32'h1;
            sh[i]['h080] = 32'h7F;
        end
        sh[0]['h044] = 32'h1000_0000; sh[0]['h045] = 32'h1000_0000; sh[0]['h046] = 32'h3;
        sh[1]['h044] = 32'h2000_0040; sh[1]['h045] = 32'h3000_0080; sh[1]['h046] = 32'h0;
    endtask

    task automatic bus_read(int w, logic [1:0] lo, string dflt);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 0; paddr = {w[9:0], lo};
        #1;
        for (int i = 0; i < 2; i++) begin
            check("R13", "setup-phase prdata", prd[i], 32'h0);
            check("R13", "setup-phase pslverr", {31'h0, perr[i]}, 32'h0);
        end
        @(negedge clk);
        penable = 1;
        #1;
        for (int i = 0; i < 2; i++) begin
            int c = cls(w, i == 0);
            bit e = (c == 0 || c == 3 || c == 4 || c == 5);
            check(tag_of(i, w, dflt), $sformatf("read data inst%0d word %h", i, w), prd[i], exp_read(i, w));
            check(tag_of(i, w, dflt), $sformatf("read err inst%0d word %h", i, w), {31'h0, perr[i]}, {31'h0, e});
        end
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic bus_write(int w, logic [31:0] d, string dflt);
        logic [1:0] erel [2];
        bit         esrr;
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 1; paddr = {w[9:0], 2'b00}; pwdata = d;
        @(negedge clk);
        penable = 1;
        #1;
        esrr = (w == 'h042) && d[9];
        for (int i = 0; i < 2; i++) begin
            int c = cls(w, i == 0);
            bit e = (c == 0 || c == 2 || c == 6 || c == 7);
            check(tag_of(i, w, dflt), $sformatf("write err inst%0d word %h", i, w), {31'h0, perr[i]}, {31'h0, e});
            erel[i] = (w == 'h046) ? (sh[i]['h046][1:0] & ~d[1:0]) : 2'b00;
        end
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
        for (int i = 0; i < 2; i++) begin
            int c = cls(w, i == 0);
            if (c == 1) sh[i][w] = d;
            if (c == 3) sh[i][0] = sh[i][0] | d;
            if (c == 4) sh[i][0] = sh[i][0] & ~d;
            #0;
            check("R6", $sformatf("release pulse inst%0d", i), {30'h0, rel[i]}, {30'h0, erel[i]});
            check("R5", $sformatf("reset request inst%0d", i), {31'h0, srr[i]}, {31'h0, esrr});
            check("R7", $sformatf("vtor0 inst%0d", i), vt0[i], sh[i]['h044]);
            check("R7", $sformatf("vtor1 inst%0d", i), vt1[i], sh[i]['h045]);
        end
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            check("R6", "release pulse length", {30'h0, rel[i]}, 32'h0);
            check("R5", "reset request length", {31'h0, srr[i]}, 32'h0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
        reset_shadow();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            check("R1", "vtor0 reset", vt0[i], sh[i]['h044]);
            check("R1", "vtor1 reset", vt1[i], sh[i]['h045]);
            check("R1", "release at reset", {30'h0, rel[i]}, 32'h0);
            check("R1", "reset request at reset", {31'h0, srr[i]}, 32'h0);
            check("R13", "idle prdata", prd[i], 32'h0);
        end

        // Reset sweep over every word offset.
        for (int w = 0; w < 1024; w++) bus_read(w, 2'b00, "R1");

        // Write sweep with an address-derived pattern, then read back.
        for (int w = 0; w < 1024; w++)
            bus_write(w, (w * 32'h9E37_79B9) ^ 32'h5A5A_C3C3, "R2");
        for (int w = 0; w < 1024; w++) bus_read(w, 2'b00, "R2");

        // R3: debug set/clear sequence.
        bus_write('h002, 32'hFFFF_FFFF, "R3");
        bus_write('h001, 32'h0000_00F0, "R3");
        bus_write('h001, 32'h0000_0F00, "R3");
        bus_read('h000, 2'b00, "R3");
        check("R3", "debug status after sets", sh[0][0], 32'h0000_0FF0);
        bus_write('h002, 32'h0000_0110, "R3");
        bus_write('h000, 32'h0000_0001, "R3");
        bus_read('h000, 2'b00, "R3");

        // R5: only bit 9 requests a reset.
        bus_write('h042, 32'hFFFF_FDFF, "R5");
        bus_write('h042, 32'h0000_0200, "R5");

        // R6: hold-bit release sequences.
        bus_write('h046, 32'h3, "R6");
        bus_write('h046, 32'h1, "R6");
        bus_write('h046, 32'h0, "R6");
        bus_write('h046, 32'h3, "R6");
        bus_write('h046, 32'h0, "R6");
        bus_read('h046, 2'b00, "R6");

        // R7: vector writes.
        bus_write('h044, 32'h0800_1000, "R7");
        bus_write('h045, 32'h0C00_2000, "R7");

        // R12: byte offsets within a word.
        bus_write('h043, 32'hCAFE_F00D, "R12");
        bus_read('h043, 2'b01, "R12");
        bus_read('h043, 2'b11, "R12");
        bus_read('h3F9, 2'b10, "R12");

        // R8, R9, R10, R11 spot checks after the sweeps.
        bus_write('h047, 32'h1, "R9");
        bus_read('h047, 2'b00, "R9");
        bus_write('h3F4, 32'hFFFF_FFFF, "R10");
        bus_read('h3F4, 2'b00, "R10");
        bus_write('h200, 32'h1234_5678, "R11");
        bus_read('h200, 2'b00, "R11");
        bus_write('h080, 32'h0000_00AA, "R8");
        bus_read('h080, 2'b00, "R8");

        @(negedge clk);
        #1;
        for (int i = 0; i < 2; i++) begin
            check("R13", "idle prdata end", prd[i], 32'h0);
            check("R13", "idle pslverr end", {31'h0, perr[i]}, 32'h0);
        end
        finish_run();
    end

endmodule